// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Registers

This block manages a one-time-programmable fuse store of 16 banks, each holding a configurable number of 32-bit words (8 by default, 4 as a build option). Each stored bit starts at 0 and, once burned to 1, stays 1 for good. Next to the store the block keeps one volatile shadow register per word. Software normally works from the shadows. The stored bits are touched only by an explicit sense or burn command.

A command port takes an opcode, a bank, a word index and write data. The block answers with a one-cycle done pulse, an error flag and read data. Burning a word keeps the controller busy for a parameterised stand-in burn time. It then refreshes that word's shadow from the store before it reports done, so a read that follows shows the burned result. After every reset the block copies the whole store into the shadows, one word per clock, and accepts no command until the copy is complete.

A separate read-only address port returns a shadow by byte offset. Software can therefore look at the shadows as a flat register window.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Bank values of 16 or more (5-bit field) and word values of WORDS_PER_BANK or more (4-bit field) are rejected. Such a command completes with rsp_done and rsp_err on its accepting edge, and it alters no stored bit and no shadow.
- R2: A burn ORs cmd_wdata into the stored word. Bits already at 1 stay 1, and zero bits in the data change nothing. The response data is the stored word after the burn.
- R3: A read (opcode 0) returns the shadow of the addressed word.
- R4: A sense (opcode 1) returns the stored word itself, whatever the shadow holds.
- R5: An override (opcode 3) replaces only the shadow and echoes the written value. The stored bits are unchanged, and the value is gone after the next reset.
- R6: A burn (opcode 2) holds cmd_ready low and raises rsp_done BURN_CYCLES+1 edges after the accepting edge. By then the word's shadow equals its stored value, which replaces any override of that word. Shadows of other words are kept.
- R7: After reset is released, cmd_ready stays low for exactly TOTAL_WORDS cycles while all shadows are loaded. Burned bits survive reset.
- R8: The address port returns the shadow of linear word n = bank*WORDS_PER_BANK + word at offset 0x400 + 0x10*n (offset 0x620 is bank 4, word 2). For a misaligned or out-of-window offset, mm_hit is 0 and mm_rdata is 0.
- R9: Single-cycle commands (read, sense, override, rejected) raise rsp_done on their accepting edge for one cycle. rsp_err is never high without rsp_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle; a command is accepted when valid and ready meet on an edge |
| cmd_op | input | 2 | 0 read, 1 sense, 2 burn, 3 override |
| cmd_bank | input | 5 | Bank number |
| cmd_word | input | 4 | Word within bank |
| cmd_wdata | input | 32 | Burn or override data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command rejected, valid with rsp_done |
| rsp_rdata | output | 32 | Response data, valid with rsp_done |
| mm_addr | input | 12 | Byte offset into the shadow window |
| mm_rdata | output | 32 | Shadow at mm_addr |
| mm_hit | output | 1 | mm_addr names a shadow |

## Verification
The bench checks that a burn with zero bits leaves earlier ones intact. A design that wrote instead of ORing would clear them. It overrides a word, then senses it and reads it again after a later burn. A controller that wrote the store on override, or that skipped the post-burn refresh, would return the wrong view. Out-of-range bank 16 and word 8 are issued as burns of all ones, and the words they would alias to are then sensed. A decoder that truncated the index would corrupt bank 0 or bank 1. Reset is counted to the cycle, and afterwards the bench confirms that overrides vanish while burned bits remain. The address window is probed at its first and last slot, one slot past the end, below the base and at a misaligned offset.

// File: rtl/otp_pkg.sv
// Package: shared opcode and sequencer state types for the fuse controller.
// Assumes: a 2-bit opcode field on the command port.
package otp_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SENSE = 2'd1,
        OP_PROG  = 2'd2,
        OP_OVR   = 2'd3
    } otp_op_e;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_BURN   = 2'd2,
        ST_RELOAD = 2'd3
    } otp_state_e;

endpackage

// File: rtl/otp_fuse_array.sv
// Module: otp_fuse_array
// Sticky bit store standing in for the fuse macro. A write can only set bits.
// Assumes: the blank state is all zeros at power-up; reset does not clear it,
// because burned fuses are permanent. rst_n only gates the checker.
module otp_fuse_array #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [WORD_W-1:0] prog_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] fuse_q [WORDS] = '{default: '0};

    // Burn: OR new ones into the addressed word
    always_ff @(posedge clk) begin
        if (prog_en) begin
            fuse_q[prog_idx] <= fuse_q[prog_idx] | prog_data;
        end
    end

    // Single combinational read port
    assign rd_data = fuse_q[rd_idx];

    // Checker state: remember the word before each burn
    logic              chk_vld;
    logic [IDX_W-1:0]  chk_idx;
    logic [WORD_W-1:0] chk_old;

    // Capture the pre-burn value for the monotonic check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld <= 1'b0;
            chk_idx <= '0;
            chk_old <= '0;
        end else begin
            chk_vld <= prog_en;
            chk_idx <= prog_idx;
            chk_old <= fuse_q[prog_idx];
        end
    end

    // R2
    fuse_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> ((fuse_q[chk_idx] & chk_old) == chk_old));

endmodule

// File: rtl/otp_shadow_bank.sv
// Module: otp_shadow_bank
// Volatile shadow registers, one per word. One write port, one read port for
// commands and one for the address window.
// Assumes: the sequencer loads every entry after reset before use.
module otp_shadow_bank #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic [WORD_W-1:0] cmd_data,
    input  logic [IDX_W-1:0]  mm_idx,
    output logic [WORD_W-1:0] mm_data
);

    logic [WORD_W-1:0] shadow_q [WORDS];

    // Write one shadow entry per cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            shadow_q[wr_idx] <= wr_data;
        end
    end

    // Read ports
    assign cmd_data = shadow_q[cmd_idx];
    assign mm_data  = shadow_q[mm_idx];

endmodule

// File: rtl/otp_ctrl_fsm.sv
// Module: otp_ctrl_fsm
// Sequencer: loads the shadows after reset, runs commands, times the burn,
// refreshes the burned word's shadow and issues responses.
// Assumes: cmd_idx and cmd_bad are decoded upstream; store and shadow reads are
// combinational.
module otp_ctrl_fsm
    import otp_pkg::*;
#(
    parameter int WORDS       = 128,
    parameter int WORD_W      = 32,
    parameter int BURN_CYCLES = 8,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int CNT_W      = $clog2(BURN_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  otp_op_e           cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              cmd_bad,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [IDX_W-1:0]  arr_idx,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              prog_en,
    output logic [IDX_W-1:0]  prog_idx,
    output logic [WORD_W-1:0] prog_data,
    input  logic [WORD_W-1:0] shd_rdata,
    output logic              shd_wr_en,
    output logic [IDX_W-1:0]  shd_wr_idx,
    output logic [WORD_W-1:0] shd_wr_data,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURN_CYCLES - 1);

    otp_state_e        state_q;
    logic [IDX_W-1:0]  init_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    // Store read index: init walk, live command, or held burn target
    always_comb begin
        case (state_q)
            ST_INIT: arr_idx = init_q;
            ST_IDLE: arr_idx = cmd_idx;
            default: arr_idx = idx_q;
        endcase
    end

    // Burn strobe fires on the last burn-time cycle
    assign prog_en   = (state_q == ST_BURN) && (cnt_q == '0);
    assign prog_idx  = idx_q;
    assign prog_data = data_q;

    // Shadow write source: init copy, override, or post-burn refresh
    always_comb begin
        shd_wr_en   = 1'b0;
        shd_wr_idx  = idx_q;
        shd_wr_data = arr_rdata;
        case (state_q)
            ST_INIT: begin
                shd_wr_en  = 1'b1;
                shd_wr_idx = init_q;
            end
            ST_IDLE: begin
                shd_wr_en   = accept && !cmd_bad && (cmd_op == OP_OVR);
                shd_wr_idx  = cmd_idx;
                shd_wr_data = cmd_wdata;
            end
            ST_RELOAD: shd_wr_en = 1'b1;
            default: ;
        endcase
    end

    // State, counters and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_INIT;
            init_q    <= '0;
            idx_q     <= '0;
            data_q    <= '0;
            cnt_q     <= '0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            case (state_q)
                ST_INIT: begin
                    init_q <= init_q + 1'b1;
                    if (init_q == LAST_IDX) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (accept) begin
                        if (cmd_bad) begin
                            rsp_done <= 1'b1;
                            rsp_err  <= 1'b1;
                        end else begin
                            case (cmd_op)
                                OP_READ: begin
                                    rsp_done  <= 1'b1;
                                    rsp_rdata <= shd_rdata;
                                end
                                OP_SENSE: begin
                                    rsp_done  <= 1'b1;
                                    rsp_rdata <= arr_rdata;
                                end
                                OP_OVR: begin
                                    rsp_done  <= 1'b1;
                                    rsp_rdata <= cmd_wdata;
                                end
                                default: begin
                                    idx_q   <= cmd_idx;
                                    data_q  <= cmd_wdata;
                                    cnt_q   <= CNT_LOAD;
                                    state_q <= ST_BURN;
                                end
                            endcase
                        end
                    end
                end
                ST_BURN: begin
                    if (cnt_q == '0) state_q <= ST_RELOAD;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: begin
                    rsp_done  <= 1'b1;
                    rsp_rdata <= arr_rdata;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R6
    burn_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_bad && cmd_op == OP_PROG) |=> (!cmd_ready && !rsp_done));

endmodule

// File: rtl/otp_fuse_ctrl.sv
// Module: otp_fuse_ctrl (top)
// Decodes bank/word into a linear index, checks range, decodes the shadow
// address window, and wires store, shadows and sequencer together.
// Assumes: 16 banks; WORDS_PER_BANK of 8 or 4; window slots 0x10 apart.
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int NUM_BANKS      = 16,
    parameter int WORDS_PER_BANK = 8,
    parameter int WORD_W         = 32,
    parameter int BURN_CYCLES    = 8,
    parameter int BANK_FIELD_W   = 5,
    parameter int WORD_FIELD_W   = 4,
    parameter int MM_ADDR_W      = 12,
    parameter int MM_BASE        = 'h400,
    localparam int TOTAL_WORDS   = NUM_BANKS * WORDS_PER_BANK,
    localparam int IDX_W         = $clog2(TOTAL_WORDS),
    localparam int SLOT_SHIFT    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [1:0]              cmd_op,
    input  logic [BANK_FIELD_W-1:0] cmd_bank,
    input  logic [WORD_FIELD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0]       cmd_wdata,
    output logic                    rsp_done,
    output logic                    rsp_err,
    output logic [WORD_W-1:0]       rsp_rdata,
    input  logic [MM_ADDR_W-1:0]    mm_addr,
    output logic [WORD_W-1:0]       mm_rdata,
    output logic                    mm_hit
);

    logic [IDX_W-1:0]  cmd_idx;
    logic              cmd_bad;
    logic [IDX_W-1:0]  arr_idx;
    logic [WORD_W-1:0] arr_rdata;
    logic              prog_en;
    logic [IDX_W-1:0]  prog_idx;
    logic [WORD_W-1:0] prog_data;
    logic              shd_wr_en;
    logic [IDX_W-1:0]  shd_wr_idx;
    logic [WORD_W-1:0] shd_wr_data;
    logic [WORD_W-1:0] shd_cmd_data;
    logic [WORD_W-1:0] shd_mm_data;
    logic [IDX_W-1:0]  mm_idx;
    int                cmd_lin;
    int                mm_off;

    // Command decode: linear index and range check
    always_comb begin
        cmd_lin = int'(cmd_bank) * WORDS_PER_BANK + int'(cmd_word);
        cmd_bad = (int'(cmd_bank) >= NUM_BANKS) || (int'(cmd_word) >= WORDS_PER_BANK);
        cmd_idx = IDX_W'(cmd_lin);
    end

    // Address window decode: aligned slot inside the window
    always_comb begin
        mm_off   = int'(mm_addr) - MM_BASE;
        mm_hit   = (mm_off >= 0) && (mm_off[SLOT_SHIFT-1:0] == '0)
                   && ((mm_off >>> SLOT_SHIFT) < TOTAL_WORDS);
        mm_idx   = IDX_W'(mm_off >>> SLOT_SHIFT);
        mm_rdata = mm_hit ? shd_mm_data : '0;
    end

    otp_fuse_array #(.WORDS(TOTAL_WORDS), .WORD_W(WORD_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_idx  (prog_idx),
        .prog_data (prog_data),
        .rd_idx    (arr_idx),
        .rd_data   (arr_rdata)
    );

    otp_shadow_bank #(.WORDS(TOTAL_WORDS), .WORD_W(WORD_W)) u_shadow (
        .clk      (clk),
        .wr_en    (shd_wr_en),
        .wr_idx   (shd_wr_idx),
        .wr_data  (shd_wr_data),
        .cmd_idx  (cmd_idx),
        .cmd_data (shd_cmd_data),
        .mm_idx   (mm_idx),
        .mm_data  (shd_mm_data)
    );

    otp_ctrl_fsm #(
        .WORDS(TOTAL_WORDS), .WORD_W(WORD_W), .BURN_CYCLES(BURN_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (otp_op_e'(cmd_op)),
        .cmd_idx     (cmd_idx),
        .cmd_bad     (cmd_bad),
        .cmd_wdata   (cmd_wdata),
        .arr_idx     (arr_idx),
        .arr_rdata   (arr_rdata),
        .prog_en     (prog_en),
        .prog_idx    (prog_idx),
        .prog_data   (prog_data),
        .shd_rdata   (shd_cmd_data),
        .shd_wr_en   (shd_wr_en),
        .shd_wr_idx  (shd_wr_idx),
        .shd_wr_data (shd_wr_data),
        .rsp_done    (rsp_done),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

    // R6
    burn_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (shd_wr_en && shd_wr_idx == $past(prog_idx)));

    // R1
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_bad) |-> !shd_wr_en);

endmodule

// File: tb/tb_otp_fuse_ctrl.sv
// Bench: a vector table walked by one loop, then directed reset, pulse and
// address-window checks.
module tb_otp_fuse_ctrl;

    localparam int BURN   = 8;
    localparam int TOTAL  = 128;
    localparam int NVEC   = 18;
    localparam logic [1:0] RD = 2'd0, SN = 2'd1, PG = 2'd2, OV = 2'd3;

    // {op, bank, word, wdata, expected data, expected err}
    localparam logic [75:0] TBL [NVEC] = '{
        {RD, 5'd4,  4'd2, 32'h0,          32'h0,          1'b0},
        {PG, 5'd4,  4'd2, 32'h0000_00F0,  32'h0000_00F0,  1'b0},
        {RD, 5'd4,  4'd2, 32'h0,          32'h0000_00F0,  1'b0},
        {SN, 5'd4,  4'd2, 32'h0,          32'h0000_00F0,  1'b0},
        {PG, 5'd4,  4'd2, 32'h0000_000F,  32'h0000_00FF,  1'b0},
        {PG, 5'd4,  4'd2, 32'h0,          32'h0000_00FF,  1'b0},
        {OV, 5'd4,  4'd2, 32'h1234_5678,  32'h1234_5678,  1'b0},
        {RD, 5'd4,  4'd2, 32'h0,          32'h1234_5678,  1'b0},
        {SN, 5'd4,  4'd2, 32'h0,          32'h0000_00FF,  1'b0},
        {OV, 5'd0,  4'd0, 32'hDEAD_BEEF,  32'hDEAD_BEEF,  1'b0},
        {PG, 5'd15, 4'd7, 32'h8000_0001,  32'h8000_0001,  1'b0},
        {RD, 5'd0,  4'd0, 32'h0,          32'hDEAD_BEEF,  1'b0},
        {PG, 5'd16, 4'd0, 32'hFFFF_FFFF,  32'h0,          1'b1},
        {PG, 5'd0,  4'd8, 32'hFFFF_FFFF,  32'h0,          1'b1},
        {SN, 5'd0,  4'd0, 32'h0,          32'h0,          1'b0},
        {SN, 5'd1,  4'd0, 32'h0,          32'h0,          1'b0},
        {PG, 5'd4,  4'd2, 32'h0000_0100,  32'h0000_01FF,  1'b0},
        {RD, 5'd4,  4'd2, 32'h0,          32'h0000_01FF,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_bank = '0;
    logic [3:0]  cmd_word = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic [11:0] mm_addr = '0;
    logic [31:0] mm_rdata;
    logic        mm_hit;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.BURN_CYCLES(BURN)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_word(cmd_word),
        .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mm_addr(mm_addr), .mm_rdata(mm_rdata),
        .mm_hit(mm_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset, then count cycles with cmd_ready low
    task automatic do_reset(output int low);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        low = 0;
        while (!cmd_ready && low < 1000) begin
            low++;
            @(negedge clk);
        end
    endtask

    // Issue one command; lat = edges from acceptance to rsp_done
    task automatic do_cmd(input logic [1:0] op, input logic [4:0] b, input logic [3:0] w,
                          input logic [31:0] d, output logic [31:0] rd,
                          output logic er, output int lat, output logic busy_ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = b; cmd_word = w; cmd_wdata = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        busy_ok = 1'b1;
        while (!rsp_done && lat < 1000) begin
            if (cmd_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic err);
        if (err) return "R1";
        case (op)
            RD: return "R3";
            SN: return "R4";
            PG: return "R2";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int          low;
        logic [31:0] rd;
        logic        er;
        int          lat;
        logic        bz;

        // R7 initial load time and idle response state
        do_reset(low);
        check("R7 reset load cycles", 32'(low), 32'(TOTAL));
        check("R9 no done at idle", {31'd0, rsp_done}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [4:0]  b;
            logic [3:0]  w;
            logic [31:0] d, ex;
            logic        ee;
            {op, b, w, d, ex, ee} = TBL[i];
            do_cmd(op, b, w, d, rd, er, lat, bz);
            check({tag_of(op, ee), " err flag"}, {31'd0, er}, {31'd0, ee});
            if (!ee) check({tag_of(op, ee), " data"}, rd, ex);
            if (op == PG && !ee) begin
                check("R6 burn latency", 32'(lat), 32'(BURN + 1));
                check("R6 held off while burning", {31'd0, bz}, 32'd1);
            end else begin
                check("R9 single-cycle latency", 32'(lat), 32'd0);
            end
        end

        // R9 done is a one-cycle pulse
        @(negedge clk);
        check("R9 done pulse width", {31'd0, rsp_done}, 32'd0);

        // R8 window before reset: override of bank 0 word 0 visible at 0x400
        mm_addr = 12'h400; #1;
        check("R8 window 0x400", mm_rdata, 32'hDEAD_BEEF);

        // R7 / R5 reset: burned bits survive, overrides are lost
        do_reset(low);
        check("R7 second reset load cycles", 32'(low), 32'(TOTAL));
        do_cmd(RD, 5'd0, 4'd0, 32'h0, rd, er, lat, bz);
        check("R5 override lost at reset", rd, 32'h0);
        do_cmd(RD, 5'd4, 4'd2, 32'h0, rd, er, lat, bz);
        check("R7 burn survives reset", rd, 32'h0000_01FF);

        // R8 address window decode
        mm_addr = 12'h620; #1;
        check("R8 0x620 data", mm_rdata, 32'h0000_01FF);
        check("R8 0x620 hit", {31'd0, mm_hit}, 32'd1);
        mm_addr = 12'hBF0; #1;
        check("R8 last slot", mm_rdata, 32'h8000_0001);
        mm_addr = 12'hC00; #1;
        check("R8 past end hit", {31'd0, mm_hit}, 32'd0);
        check("R8 past end data", mm_rdata, 32'h0);
        mm_addr = 12'h624; #1;
        check("R8 misaligned hit", {31'd0, mm_hit}, 32'd0);
        mm_addr = 12'h3F0; #1;
        check("R8 below base hit", {31'd0, mm_hit}, 32'd0);
        mm_addr = 12'h400; #1;
        check("R8 0x400 after reset", mm_rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule